// File: doc/BRIEF.md
# Binary Floating-Point Rounding Packer

This block turns an exact intermediate value into a packed binary floating-point word. The value arrives as a sign, a signed unbiased exponent and a 64-bit mantissa. The highest set bit of the mantissa carries the weight two to the power of the exponent. The packed result uses a format chosen by two parameters, the exponent field width and the fraction width. The half, single and double layouts are all reachable this way. The default is the 8/23 single layout.

Two rounding modes are selectable per input: nearest with ties to even, and round to odd. The second mode is meant for double-rounding chains. The block covers these cases:

- zero input
- exponent overflow
- gradual underflow into subnormals
- loss of the whole value below the smallest subnormal
- a round-up whose carry ripples through the fraction into the exponent field, and on to infinity

Inputs are taken with a single valid strobe. The result appears a fixed one or two cycles later, as set by a parameter.

Top module: `fpr_round_pack`

## Requirements
- R1: A zero mantissa yields a zero magnitude (exponent and fraction fields all zero) with the sign bit copied from sign_i, in both modes.
- R2: With mode_i = 0 (nearest, ties to even), a biased exponent (exp_i + 2^(EXP_W-1) - 1) above 2^EXP_W - 2 yields a signed infinity: exponent field all ones, fraction zero.
- R3: With mode_i = 1 (round to odd), the same overflow yields the largest finite magnitude: exponent field 2^EXP_W - 2, fraction all ones. This mode never produces an all-ones exponent field.
- R4: A value with a positive biased exponent and no discarded bits is packed exactly. The exponent field holds the biased exponent, the fraction holds the bits below the leading one, and the leading one itself is dropped.
- R5: In mode 0 the magnitude is incremented exactly when the discarded bits exceed half a unit in the last place, or equal half with the kept LSB set. The increment carries into the exponent field, and can carry up to infinity.
- R6: In mode 1 no increment is made. If any discarded bit is set, the fraction LSB is forced to 1.
- R7: A biased exponent of 0 or below gives exponent field 0 and a subnormal fraction, shifted right by one extra place per unit below 1 and rounded by the same rules. A subnormal that rounds up past all-ones fraction becomes the smallest normal.
- R8: When the required right shift exceeds the leading one position plus one, mode 0 gives a signed zero and mode 1 gives the smallest signed subnormal (fraction 1). When the shift equals that position plus one, the value is a pure rounding case.
- R9: A mantissa narrower than the fraction (leading one at or below position MAN_W) is shifted left and packed without rounding.
- R10: After reset valid_o and result_o are 0. Each accepted input produces exactly one valid_o pulse LAT cycles after the edge that samples valid_i.
- R11: result_o holds its last value on every cycle where valid_o is low.
- R12: No NaN encoding (all-ones exponent with a nonzero fraction) is ever produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operands valid this cycle |
| sign_i | input | 1 | Sign of the value (1 = negative) |
| exp_i | input | 16 | Signed unbiased exponent, weight of the mantissa's highest set bit |
| mant_i | input | 64 | Mantissa, any position for the leading one; zero means a zero value |
| mode_i | input | 1 | Rounding mode: 0 nearest ties to even, 1 round to odd |
| valid_o | output | 1 | Result valid |
| result_o | output | EXP_W+MAN_W+1 | Packed result: sign, exponent field, fraction |

## Verification
The assertions take for granted the following conditions:

- valid_i stays low while reset is asserted, so that the latency property can look back LAT cycles across the reset release.
- EXP_W is at most 15.
- mode_i is only 0 or 1.

The bench keeps within these conditions:

- It holds valid_i low through reset.
- It uses the default single layout.
- It draws exponents from a window of about plus or minus 160. This covers the overflow threshold, the whole subnormal range and the total-loss region without ever reaching the 16-bit exponent limits.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int unsigned MANT_IN_W = 64;
  localparam int unsigned POS_W     = $clog2(MANT_IN_W);
  localparam int unsigned EXP_IN_W  = 16;
  localparam int unsigned SHIFT_W   = EXP_IN_W + 2;

  typedef enum logic [1:0] {
    K_ZERO = 2'd0,
    K_OVF  = 2'd1,
    K_TINY = 2'd2,
    K_NORM = 2'd3
  } kind_e;

  typedef enum logic {
    RM_NEAR_EVEN = 1'b0,
    RM_ODD       = 1'b1
  } rmode_e;

  typedef struct packed {
    kind_e                       kind;
    logic                        sign;
    rmode_e                      mode;
    logic [MANT_IN_W-1:0]        mant;
    logic signed [SHIFT_W-1:0]   shift;
  } plan_t;
endpackage

// File: rtl/fpr_lead_one.sv
module fpr_lead_one #(
  parameter int unsigned W  = 64,
  parameter int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o,
  output logic          found_o
);
  // per-bit "no higher bit set" chain
  logic [W:0] clear_above;
  assign clear_above[W] = 1'b1;

  for (genvar g = W - 1; g >= 0; g--) begin : g_chain
    assign clear_above[g] = clear_above[g+1] & ~vec_i[g];
  end

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i] && clear_above[i+1]) pos_o = PW'(i);
    end
  end

  assign found_o = ~clear_above[0];
endmodule

// File: rtl/fpr_classify.sv
module fpr_classify
  import fpr_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic                        sign_i,
  input  logic signed [EXP_IN_W-1:0]  exp_i,
  input  logic [MANT_IN_W-1:0]        mant_i,
  input  logic                        mode_i,
  output plan_t                       plan_o,
  output logic [EXP_W-1:0]            efld_o
);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX_B = (1 << EXP_W) - 2;
  localparam logic signed [SHIFT_W-1:0] BIAS_S = SHIFT_W'(BIAS);
  localparam logic signed [SHIFT_W-1:0] EMAX_S = SHIFT_W'(EMAX_B);
  localparam logic signed [SHIFT_W-1:0] MAN_S  = SHIFT_W'(MAN_W);
  localparam logic signed [SHIFT_W-1:0] ONE_S  = SHIFT_W'(1);

  logic [POS_W-1:0]           pos;
  logic                       found;
  logic signed [SHIFT_W-1:0]  biased, pos_s, sh_norm, shift;
  logic                       sub, tiny;
  logic [MANT_IN_W-1:0]       mant_m;

  fpr_lead_one #(.W(MANT_IN_W), .PW(POS_W)) u_lead (
    .vec_i   (mant_i),
    .pos_o   (pos),
    .found_o (found)
  );

  always_comb begin
    biased  = $signed({{(SHIFT_W-EXP_IN_W){exp_i[EXP_IN_W-1]}}, exp_i}) + BIAS_S;
    pos_s   = $signed({{(SHIFT_W-POS_W){1'b0}}, pos});
    sh_norm = pos_s - MAN_S;
    sub     = (biased <= 0);
    shift   = sub ? (sh_norm + ONE_S - biased) : sh_norm;
    tiny    = (shift > (pos_s + ONE_S));
    mant_m  = mant_i;
    if (!sub) mant_m[pos] = 1'b0;  // hidden bit leaves the fraction
    efld_o  = sub ? '0 : biased[EXP_W-1:0];

    plan_o.sign  = sign_i;
    plan_o.mode  = rmode_e'(mode_i);
    plan_o.mant  = mant_m;
    plan_o.shift = shift;
    if (!found)                plan_o.kind = K_ZERO;
    else if (biased > EMAX_S)  plan_o.kind = K_OVF;
    else if (tiny)             plan_o.kind = K_TINY;
    else                       plan_o.kind = K_NORM;
  end
endmodule

// File: rtl/fpr_round.sv
module fpr_round
  import fpr_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic                     valid_i,
  input  plan_t                    plan_i,
  input  logic [EXP_W-1:0]         efld_i,
  output logic [EXP_W+MAN_W:0]     word_o
);
  localparam int unsigned BODY_W = EXP_W + MAN_W;
  localparam int unsigned SH_W   = POS_W + 1;

  logic [SH_W-1:0]       shr, shl;
  logic [MAN_W-1:0]      kept_lo, lfrac;
  logic [MANT_IN_W-1:0]  mask, adj, half_sel;
  logic                  half, one, half_adj, sticky, rshift;
  logic [BODY_W-1:0]     base, body;

  always_comb begin
    rshift   = (plan_i.shift > 0);
    shr      = plan_i.shift[SH_W-1:0];
    shl      = SH_W'(-plan_i.shift);
    kept_lo  = MAN_W'(plan_i.mant >> shr);
    lfrac    = MAN_W'(plan_i.mant << shl);
    half_sel = {{(MANT_IN_W-1){1'b0}}, 1'b1} << (shr - SH_W'(1));
    mask     = ({{(MANT_IN_W-1){1'b0}}, 1'b1} << shr) - {{(MANT_IN_W-1){1'b0}}, 1'b1};
    one      = kept_lo[0];
    half     = |(plan_i.mant & half_sel);
    // tie with even LSB: pull the tail just below half so it rounds down
    adj      = plan_i.mant - {{(MANT_IN_W-1){1'b0}}, half & ~one};
    half_adj = |(adj & half_sel);
    sticky   = |(plan_i.mant & mask);
    base     = {efld_i, kept_lo};
    if (plan_i.mode == RM_ODD) body = base | BODY_W'(sticky);
    else                       body = base + BODY_W'(half_adj);

    unique case (plan_i.kind)
      K_ZERO: word_o = {plan_i.sign, {BODY_W{1'b0}}};
      K_OVF: begin
        if (plan_i.mode == RM_ODD)
          word_o = {plan_i.sign, {(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
        else
          word_o = {plan_i.sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      end
      K_TINY: begin
        if (plan_i.mode == RM_ODD) word_o = {plan_i.sign, BODY_W'(1)};
        else                       word_o = {plan_i.sign, {BODY_W{1'b0}}};
      end
      default: begin
        if (rshift) word_o = {plan_i.sign, body};
        else        word_o = {plan_i.sign, efld_i, lfrac};
      end
    endcase
  end

  always_comb begin
    if (valid_i) begin
      AST_ODD_FINITE: assert (!(plan_i.mode == RM_ODD && (&word_o[BODY_W-1:MAN_W]))); // R3
      AST_NEAR_MONO: assert (!(plan_i.kind == K_NORM && rshift && plan_i.mode == RM_NEAR_EVEN)
                             || (word_o[BODY_W-1:0] >= base)); // R5
    end
  end
endmodule

// File: rtl/fpr_round_pack.sv
module fpr_round_pack
  import fpr_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  parameter int unsigned LAT   = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic                        sign_i,
  input  logic signed [15:0]          exp_i,
  input  logic [63:0]                 mant_i,
  input  logic                        mode_i,
  output logic                        valid_o,
  output logic [EXP_W+MAN_W:0]        result_o
);
  localparam int unsigned RES_W = EXP_W + MAN_W + 1;

  plan_t             plan_c, plan_r;
  logic [EXP_W-1:0]  efld_c, efld_r;
  logic              vld_r;
  logic [RES_W-1:0]  word_c;

  fpr_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .sign_i (sign_i),
    .exp_i  (exp_i),
    .mant_i (mant_i),
    .mode_i (mode_i),
    .plan_o (plan_c),
    .efld_o (efld_c)
  );

  if (LAT == 2) begin : g_two
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_r  <= 1'b0;
        plan_r <= '0;
        efld_r <= '0;
      end else begin
        vld_r <= valid_i;
        if (valid_i) begin
          plan_r <= plan_c;
          efld_r <= efld_c;
        end
      end
    end
  end else begin : g_one
    assign vld_r  = valid_i;
    assign plan_r = plan_c;
    assign efld_r = efld_c;
  end

  fpr_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rnd (
    .valid_i (vld_r),
    .plan_i  (plan_r),
    .efld_i  (efld_r),
    .word_o  (word_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= vld_r;
      if (vld_r) result_o <= word_c;
    end
  end

  if (LAT == 2) begin : g_a2
    AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == $past(valid_i, 2)); // R10
  end else begin : g_a1
    AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == $past(valid_i)); // R10
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o)); // R11

  AST_NO_NAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !((&result_o[RES_W-2:MAN_W]) && (|result_o[MAN_W-1:0]))); // R12
endmodule

// File: tb/tb_fpr_round_pack.sv
module tb_fpr_round_pack;
  localparam int CLK_PERIOD = 10;
  localparam int E_W  = 8;
  localparam int M_W  = 23;
  localparam int LATN = 2;
  localparam int R_W  = E_W + M_W + 1;
  localparam int BIAS = (1 << (E_W - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, sign_i = 1'b0, mode_i = 1'b0;
  logic signed [15:0] exp_i = '0;
  logic [63:0] mant_i = '0;
  logic valid_o;
  logic [R_W-1:0] result_o;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    logic [R_W-1:0] expv;
    int             due;
    string          tag;
  } item_t;
  item_t sb_q[$];

  fpr_round_pack #(.EXP_W(E_W), .MAN_W(M_W), .LAT(LATN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sign_i(sign_i),
    .exp_i(exp_i), .mant_i(mant_i), .mode_i(mode_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [R_W-1:0] ref_pack(logic s, int e, logic [63:0] m, logic md);
    int hb, be, sh, ef;
    logic [63:0] mm, disc, halfv, mask;
    logic [M_W-1:0] kept;
    logic [R_W-2:0] body;
    logic up;
    if (m == 0) return {s, {(R_W-1){1'b0}}};
    hb = 0;
    for (int i = 0; i < 64; i++) if (m[i]) hb = i;
    be = e + BIAS;
    if (be > (1 << E_W) - 2)
      return md ? {s, {(E_W-1){1'b1}}, 1'b0, {M_W{1'b1}}} : {s, {E_W{1'b1}}, {M_W{1'b0}}};
    sh = hb - M_W;
    ef = be;
    if (be <= 0) begin sh = sh + 1 - be; ef = 0; end
    if (sh > hb + 1) return md ? {s, (R_W-1)'(1)} : {s, {(R_W-1){1'b0}}};
    mm = m;
    if (ef != 0) mm[hb] = 1'b0;
    if (sh <= 0) begin
      mm = mm << (-sh);
      return {s, ef[E_W-1:0], mm[M_W-1:0]};
    end
    mask  = (sh >= 64) ? '1 : ((64'd1 << sh) - 64'd1);
    disc  = mm & mask;
    halfv = 64'd1 << (sh - 1);
    kept  = (sh >= 64) ? '0 : M_W'(mm >> sh);
    body  = {ef[E_W-1:0], kept};
    if (md) body = body | (R_W-1)'(disc != 0);
    else begin
      up   = (disc > halfv) || ((disc == halfv) && kept[0]);
      body = body + (R_W-1)'(up);
    end
    return {s, body};
  endfunction

  // driver: one operand per negedge, expected result pushed to scoreboard
  task automatic send(logic s, int e, logic [63:0] m, logic md, logic [R_W-1:0] expv, string tag);
    item_t it;
    @(negedge clk);
    valid_i = 1'b1; sign_i = s; exp_i = 16'(e); mant_i = m; mode_i = md;
    it.expv = expv; it.due = cyc + LATN; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    item_t it;
    if (rst_n && valid_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10 unexpected valid", 1, 0);
      end else begin
        it = sb_q.pop_front();
        check(result_o == it.expv, it.tag, longint'(result_o), longint'(it.expv));
        check(cyc == it.due, "R10 latency", cyc, it.due);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [R_W-1:0] held;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0 && result_o == '0, "R10 reset state", longint'(result_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(0, 5, 64'd0, 0, 32'h0000_0000, "R1 +zero");
    send(1, -40, 64'd0, 1, 32'h8000_0000, "R1 -zero odd");
    send(0, 0, 64'h8000_0000_0000_0000, 0, 32'h3F80_0000, "R4 one");
    send(0, -126, 64'h8000_0000_0000_0000, 0, 32'h0080_0000, "R4 min normal");
    send(0, 127, 64'hFFFF_FF00_0000_0000, 0, 32'h7F7F_FFFF, "R4 max finite");
    send(0, 0, 64'd3, 0, 32'h3FC0_0000, "R9 narrow 1.5");
    send(1, 2, 64'd5, 1, 32'hC0A0_0000, "R9 narrow -5 odd");
    send(0, 0, 64'h8000_0080_0000_0000, 0, 32'h3F80_0000, "R5 tie to even down");
    send(0, 0, 64'h8000_0180_0000_0000, 0, 32'h3F80_0002, "R5 tie to even up");
    send(0, 0, 64'h8000_0080_0000_0001, 0, 32'h3F80_0001, "R5 above half");
    send(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'h4000_0000, "R5 carry into exponent");
    send(1, 127, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'hFF80_0000, "R5 carry to infinity");
    send(0, 0, 64'h8000_0080_0000_0000, 1, 32'h3F80_0001, "R6 odd sticky");
    send(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 32'h3FFF_FFFF, "R6 odd no carry");
    send(0, 0, 64'h8000_0180_0000_0000, 1, 32'h3F80_0001, "R6 odd lsb already set");
    send(0, 128, 64'h8000_0000_0000_0000, 0, 32'h7F80_0000, "R2 overflow inf");
    send(1, 300, 64'd1, 0, 32'hFF80_0000, "R2 overflow -inf");
    send(0, 128, 64'h8000_0000_0000_0000, 1, 32'h7F7F_FFFF, "R3 overflow max");
    send(1, 127, 64'hFFFF_FFFF_FFFF_FFFF, 1, 32'hFF7F_FFFF, "R3 odd near top");
    send(0, -127, 64'h8000_0000_0000_0000, 0, 32'h0040_0000, "R7 subnormal half");
    send(0, -149, 64'h8000_0000_0000_0000, 0, 32'h0000_0001, "R7 min subnormal");
    send(0, -127, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'h0080_0000, "R7 subnormal to normal");
    send(1, -140, 64'hC000_0000_0000_0001, 1, 32'h8000_0301, "R7 subnormal odd");
    send(0, -150, 64'h8000_0000_0000_0000, 0, 32'h0000_0000, "R8 tie at edge to zero");
    send(0, -150, 64'h8000_0000_0000_0001, 0, 32'h0000_0001, "R8 above half at edge");
    send(0, -150, 64'h8000_0000_0000_0000, 1, 32'h0000_0001, "R8 odd at edge");
    send(0, -151, 64'h8000_0000_0000_0000, 0, 32'h0000_0000, "R8 far underflow zero");
    send(1, -400, 64'h1234, 1, 32'h8000_0001, "R8 far underflow odd");
    idle();
    while (sb_q.size() != 0) @(negedge clk);

    held = result_o;
    repeat (5) begin
      @(negedge clk);
      check(result_o == held && !valid_o, "R11 hold when idle", longint'(result_o), longint'(held));
    end

    for (int k = 0; k < 400; k++) begin
      logic [63:0] m;
      int e;
      logic s, md;
      m  = {$urandom(), $urandom()} >> $urandom_range(0, 63);
      if (m == 0) m = 64'd1;
      e  = int'($urandom_range(0, 320)) - 165;
      s  = 1'($urandom());
      md = 1'($urandom());
      send(s, e, m, md, ref_pack(s, e, m, md), "R12 random vs model");
      if ((k % 7) == 3) idle();
    end
    idle();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule